// File: doc/BRIEF.md
# Gated Station Address Register Bank

This block keeps the 48-bit station address of an Ethernet controller, plus a 16-bit mode word whose top bit turns on promiscuous reception. The address lives in three 16-bit slots, and the mode word sits in a fourth host-visible slot. Three sources can load the bank:
- a serial-memory word stream, which runs after every hardware reset and on a reprogram command;
- an initialization-block word stream, which runs on an init command;
- host register writes.

The host port only reaches the bank while the controller is stopped or suspended. The stored contents have no reset at all.

Both load streams are valid/ready. A word moves on a cycle where valid and ready are both high. While a source is busy, its ready is held high, and it drops only to yield to a stream of higher priority. A producer must hold its valid and word stable until the word is taken.

A received destination address is compared each cycle it is presented. The accept decision appears one clock later as a registered valid/flag pair. The compare path has no back-pressure.

Top module: `staddr_bank`

## Requirements
- R1: Host slot index 0 maps to address bits 15:0, index 1 to bits 31:16, index 2 to bits 47:32 and index 3 to the mode word. A host read returns the 16-bit value in bits 15:0 of `host_rdata`.
- R2: Bits 31:16 of `host_rdata` always read as zero, and bits 31:16 of `host_wdata` are never stored.
- R3: When both `stop` and `spnd` are low, host writes change nothing and host reads return zero.
- R4: Asserting `rst_n` low leaves the three address slots and the mode word unchanged.
- R5: After reset is released, `ee_busy` is 1 and `ee_ready` is high. The next three serial-memory words go to slots 0, 1 and 2, in that order.
- R6: A one-cycle `ee_reprog` pulse sets `ee_busy` and restarts the three-word load at slot 0. The mode word is left untouched.
- R7: A one-cycle `init_cmd` pulse sets `ib_busy`. The next four init words go to slots 0, 1, 2 and then the mode word.
- R8: When mode bit 15 is 1, every presented destination is accepted.
- R9: When mode bit 15 is 0, a destination is accepted only if all 48 bits equal the stored address. `acc_valid` and `acc_ok` appear on the clock after `rx_valid`.
- R10: In any cycle where a serial-memory word is taken, `ib_ready` is low and a host write is dropped. In any cycle where an init word is taken, a host write is dropped.
- R11: `ee_busy` clears on the clock that takes the third serial-memory word. `ee_done` is high for exactly that one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low; starts a serial-memory load |
| stop | input | 1 | Controller stopped; opens host access |
| spnd | input | 1 | Controller suspended; opens host access |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host slot index (0-2 address, 3 mode) |
| host_wdata | input | 32 | Host write data, bits 31:16 ignored |
| host_rdata | output | 32 | Host read data |
| ee_reprog | input | 1 | Serial-memory reload command pulse |
| ee_valid | input | 1 | Serial-memory word valid |
| ee_ready | output | 1 | Serial-memory word accepted when high with valid |
| ee_word | input | 16 | Serial-memory word |
| ee_busy | output | 1 | Reload command bit, self-clearing |
| ee_done | output | 1 | One-cycle reload completion pulse |
| init_cmd | input | 1 | Initialization command pulse |
| ib_valid | input | 1 | Init word valid |
| ib_ready | output | 1 | Init word accepted when high with valid |
| ib_word | input | 16 | Init word |
| ib_busy | output | 1 | Init load in progress |
| rx_valid | input | 1 | Destination address present |
| rx_dst | input | 48 | Received destination address |
| acc_valid | output | 1 | Accept decision valid |
| acc_ok | output | 1 | Frame accepted |

## Verification
Several properties are checked on every cycle:
- an ungated host write leaves the address stable;
- a serial-memory transfer blocks the init stream;
- the completion pulse lasts one cycle and coincides with the busy bit being low;
- promiscuous mode forces acceptance;
- an address mismatch without promiscuous mode yields a reject;
- the upper read half is zero.

Other behaviour can only be shown by the bench's scenarios:
- the slot order of each load stream;
- that the contents survive a hardware reset;
- the combined outcome of a serial-memory load, an init load and a host write arriving together;
- the exact accept decisions, which a scoreboard compares.

// File: rtl/staddr_pkg.sv
package staddr_pkg;
  localparam int WORD_W   = 16;
  localparam int BUS_W    = 32;
  localparam int NSLOT    = 3;
  localparam int ADDR_W   = NSLOT * WORD_W;
  localparam int IDX_W    = 2;
  localparam int PROM_BIT = 15;
  localparam int EE_WORDS = NSLOT;
  localparam int IB_WORDS = NSLOT + 1;

  typedef enum logic [IDX_W-1:0] {
    SL_LO   = 2'd0,
    SL_MID  = 2'd1,
    SL_HI   = 2'd2,
    SL_MODE = 2'd3
  } slot_e;
endpackage

// File: rtl/staddr_seq.sv
module staddr_seq #(
  parameter int NWORDS     = 3,
  parameter int WORD_W     = 16,
  parameter int IDX_W      = 2,
  parameter bit RESET_BUSY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              block,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_word,
  output logic              busy,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign in_ready = busy && !block;
  assign fire     = in_valid && in_ready;
  assign wr_en    = fire;
  assign wr_idx   = idx_q;
  assign wr_word  = in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= RESET_BUSY;
      idx_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        idx_q <= '0;
      end else if (fire) begin
        if (idx_q == LAST) begin
          busy  <= 1'b0;
          idx_q <= '0;
          done  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && idx_q == LAST && !start) |=> (!busy && done)); // R11
endmodule

// File: rtl/staddr_regs.sv
module staddr_regs
  import staddr_pkg::*;
(
  input  logic              clk,
  input  logic              ee_we,
  input  logic [IDX_W-1:0]  ee_idx,
  input  logic [WORD_W-1:0] ee_word,
  input  logic              ib_we,
  input  logic [IDX_W-1:0]  ib_idx,
  input  logic [WORD_W-1:0] ib_word,
  input  logic              h_we,
  input  logic [IDX_W-1:0]  h_idx,
  input  logic [WORD_W-1:0] h_word,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] mode
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (ee_we && ee_idx == IDX_W'(k))      slot_q <= ee_word;
      else if (ib_we && ib_idx == IDX_W'(k)) slot_q <= ib_word;
      else if (h_we && h_idx == IDX_W'(k))   slot_q <= h_word;
    end
    assign addr[k*WORD_W +: WORD_W] = slot_q;
  end

  logic [WORD_W-1:0] mode_q;
  always_ff @(posedge clk) begin
    if (ib_we && ib_idx == SL_MODE)     mode_q <= ib_word;
    else if (h_we && h_idx == SL_MODE)  mode_q <= h_word;
  end
  assign mode = mode_q;
endmodule

// File: rtl/staddr_match.sv
module staddr_match
  import staddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_dst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prom,
  output logic              acc_valid,
  output logic              acc_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_ok    <= 1'b0;
    end else begin
      acc_valid <= rx_valid;
      acc_ok    <= rx_valid && (prom || (rx_dst == addr));
    end
  end

  AST_PROM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && prom) |=> (acc_valid && acc_ok)); // R8
  AST_MISMATCH_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !prom && rx_dst != addr) |=> (acc_valid && !acc_ok)); // R9
endmodule

// File: rtl/staddr_bank.sv
module staddr_bank
  import staddr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop,
  input  logic        spnd,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        ee_reprog,
  input  logic        ee_valid,
  output logic        ee_ready,
  input  logic [15:0] ee_word,
  output logic        ee_busy,
  output logic        ee_done,
  input  logic        init_cmd,
  input  logic        ib_valid,
  output logic        ib_ready,
  input  logic [15:0] ib_word,
  output logic        ib_busy,
  input  logic        rx_valid,
  input  logic [47:0] rx_dst,
  output logic        acc_valid,
  output logic        acc_ok
);
  logic              gate;
  logic              ee_we, ib_we, h_we;
  logic [IDX_W-1:0]  ee_idx, ib_idx;
  logic [WORD_W-1:0] ee_w, ib_w;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] mode;
  logic              ib_done;
  logic              unused_bits;
  logic [WORD_W-1:0] rd_word;

  assign gate        = stop || spnd;
  assign unused_bits = ^host_wdata[BUS_W-1:WORD_W] ^ ib_done;

  staddr_seq #(.NWORDS(EE_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .RESET_BUSY(1'b1)) u_ee (
    .clk(clk), .rst_n(rst_n), .start(ee_reprog), .block(1'b0),
    .in_valid(ee_valid), .in_ready(ee_ready), .in_word(ee_word),
    .wr_en(ee_we), .wr_idx(ee_idx), .wr_word(ee_w),
    .busy(ee_busy), .done(ee_done)
  );

  staddr_seq #(.NWORDS(IB_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .RESET_BUSY(1'b0)) u_ib (
    .clk(clk), .rst_n(rst_n), .start(init_cmd), .block(ee_we),
    .in_valid(ib_valid), .in_ready(ib_ready), .in_word(ib_word),
    .wr_en(ib_we), .wr_idx(ib_idx), .wr_word(ib_w),
    .busy(ib_busy), .done(ib_done)
  );

  assign h_we = host_we && gate && !ee_we && !ib_we;

  staddr_regs u_regs (
    .clk(clk),
    .ee_we(ee_we), .ee_idx(ee_idx), .ee_word(ee_w),
    .ib_we(ib_we), .ib_idx(ib_idx), .ib_word(ib_w),
    .h_we(h_we), .h_idx(host_addr), .h_word(host_wdata[WORD_W-1:0]),
    .addr(addr), .mode(mode)
  );

  always_comb begin
    unique case (host_addr)
      SL_LO:   rd_word = addr[0*WORD_W +: WORD_W];
      SL_MID:  rd_word = addr[1*WORD_W +: WORD_W];
      SL_HI:   rd_word = addr[2*WORD_W +: WORD_W];
      default: rd_word = mode;
    endcase
  end

  assign host_rdata = gate ? {{(BUS_W-WORD_W){1'b0}}, rd_word} : '0;

  staddr_match u_match (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_dst(rx_dst),
    .addr(addr), .prom(mode[PROM_BIT]),
    .acc_valid(acc_valid), .acc_ok(acc_ok)
  );

  always_comb begin
    AST_UPPER_ZERO: assert (host_rdata[BUS_W-1:WORD_W] == '0); // R2
  end

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !gate && !ee_we && !ib_we) |=> ($stable(addr) && $stable(mode))); // R3
  AST_EE_BLOCKS_IB: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |-> !ib_ready); // R10
endmodule

// File: tb/tb_staddr_bank.sv
module tb_staddr_bank;
  logic        clk = 1'b0;
  logic        rst_n, stop, spnd, host_we;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        ee_reprog, ee_valid, ee_ready, ee_busy, ee_done;
  logic [15:0] ee_word;
  logic        init_cmd, ib_valid, ib_ready, ib_busy;
  logic [15:0] ib_word;
  logic        rx_valid, acc_valid, acc_ok;
  logic [47:0] rx_dst;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  staddr_bank dut (.*);

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    host_addr = a;
    #1;
    check(host_rdata == exp, tag, {16'h0, host_rdata}, {16'h0, exp});
  endtask

  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic ee_send(input logic [15:0] w);
    @(negedge clk);
    ee_valid = 1; ee_word = w;
    while (!ee_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ee_valid = 0;
  endtask

  task automatic ib_send(input logic [15:0] w);
    @(negedge clk);
    ib_valid = 1; ib_word = w;
    while (!ib_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ib_valid = 0;
  endtask

  task automatic rx_send(input logic [47:0] d, input bit exp);
    @(negedge clk);
    rx_valid = 1; rx_dst = d;
    exp_q.push_back(exp);
    @(negedge clk);
    rx_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (acc_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected accept output", 48'(acc_ok), 48'h0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(acc_ok == e, "R8/R9 accept decision", 48'(acc_ok), 48'(e));
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; stop = 1; spnd = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    ee_reprog = 0; ee_valid = 0; ee_word = 0; init_cmd = 0; ib_valid = 0; ib_word = 0;
    rx_valid = 0; rx_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R5
    check(ee_busy == 1 && ee_ready == 1, "R5 busy after reset", {ee_busy, ee_ready}, 2'b11);
    check(ee_done == 0 && acc_valid == 0 && ib_busy == 0, "R5 reset outputs", {ee_done, acc_valid, ib_busy}, 0);

    ee_send(16'hA1B2);
    ee_send(16'hC3D4);
    ee_send(16'hE5F6);
    check(ee_done == 1 && ee_busy == 0, "R11 done after third word", {ee_done, ee_busy}, 2'b10);
    @(negedge clk);
    check(ee_done == 0, "R11 done one cycle", 48'(ee_done), 0);

    // R1 slot layout
    rd(0, 32'h0000A1B2, "R1 slot0");
    rd(1, 32'h0000C3D4, "R1 slot1");
    rd(2, 32'h0000E5F6, "R5 slot2 order");

    // R3 gating
    stop = 0; spnd = 0;
    hwr(0, 32'h00001234);
    rd(0, 32'h0, "R3 read gated");
    spnd = 1;
    rd(0, 32'h0000A1B2, "R3 write ignored");
    // R2 upper bits dropped
    hwr(1, 32'hFFFF5555);
    rd(1, 32'h00005555, "R2 upper zero");
    hwr(1, 32'h0000C3D4);
    spnd = 0; stop = 1;

    // R9 exact match, promiscuous off
    hwr(3, 32'h0);
    rx_send(48'hE5F6_C3D4_A1B2, 1'b1);
    rx_send(48'hE5F6_C3D4_A1B3, 1'b0);
    rx_send(48'h65F6_C3D4_A1B2, 1'b0);
    repeat (2) @(negedge clk);

    // R7 init load
    @(negedge clk); init_cmd = 1;
    @(negedge clk); init_cmd = 0;
    check(ib_busy == 1, "R7 init busy", 48'(ib_busy), 1);
    ib_send(16'h0102);
    ib_send(16'h0304);
    ib_send(16'h0506);
    ib_send(16'h8000);
    rd(0, 32'h00000102, "R7 slot0");
    rd(2, 32'h00000506, "R7 slot2");
    rd(3, 32'h00008000, "R7 mode");
    // R8 promiscuous
    rx_send(48'h1234_5678_9ABC, 1'b1);
    rx_send(48'h0506_0304_0102, 1'b1);
    repeat (2) @(negedge clk);

    // R6 reprogram
    @(negedge clk); ee_reprog = 1;
    @(negedge clk); ee_reprog = 0;
    check(ee_busy == 1, "R6 reprog busy", 48'(ee_busy), 1);
    ee_send(16'hA1B2);
    ee_send(16'hC3D4);
    ee_send(16'hE5F6);
    rd(0, 32'h0000A1B2, "R6 slot0 reloaded");
    rd(2, 32'h0000E5F6, "R6 slot2 reloaded");
    rd(3, 32'h00008000, "R6 mode untouched");

    // R10 priority
    @(negedge clk); ee_reprog = 1; init_cmd = 1;
    @(negedge clk); ee_reprog = 0; init_cmd = 0;
    ee_valid = 1; ee_word = 16'h7000;
    ib_valid = 1; ib_word = 16'h0B0B;
    host_we = 1; host_addr = 2; host_wdata = 32'h0000DEAD;
    #1;
    check(ee_ready == 1 && ib_ready == 0, "R10 init stalled by serial load", {ee_ready, ib_ready}, 2'b10);
    @(negedge clk);
    ee_valid = 0; host_we = 0;
    rd(2, 32'h0000E5F6, "R10 host write dropped");
    rd(0, 32'h00007000, "R10 serial word won");
    check(ib_ready == 1, "R10 init resumes", 48'(ib_ready), 1);
    @(negedge clk);
    ib_valid = 0;
    ib_send(16'h1C1C);
    ib_send(16'h2D2D);
    ib_send(16'h0000);
    ee_send(16'h3E3E);
    ee_send(16'h4F4F);
    rd(0, 32'h00000B0B, "R10 slot0 final");
    rd(1, 32'h00003E3E, "R10 slot1 final");
    rd(2, 32'h00004F4F, "R10 slot2 final");
    rd(3, 32'h00000000, "R10 mode final");
    rx_send(48'h4F4F_3E3E_0B0B, 1'b1);
    rx_send(48'h4F4F_3E3E_0B0A, 1'b0);
    repeat (2) @(negedge clk);

    // R4 contents survive reset
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ee_busy == 1, "R4 reload pending after reset", 48'(ee_busy), 1);
    rd(0, 32'h00000B0B, "R4 slot0 kept");
    rd(1, 32'h00003E3E, "R4 slot1 kept");
    rd(2, 32'h00004F4F, "R4 slot2 kept");
    rd(3, 32'h00000000, "R4 mode kept");
    ee_send(16'h1111);
    ee_send(16'h2222);
    ee_send(16'h3333);
    check(ee_done == 1, "R11 done after reset load", 48'(ee_done), 1);
    rd(1, 32'h00002222, "R5 slot1 after reset load");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all decisions seen", 48'(exp_q.size()), 0);
    finish_run();
  end
endmodule